// File: doc/BRIEF.md
# Processor Halt and Wake Controller

This block keeps the halt state of a small processor core. When the instruction decoder reports a halt opcode (0xF4) with a one-cycle strobe, the controller enters the halted state and drops the fetch-enable output, so the core stops issuing instruction fetches. The core stays stopped until a wake event qualifies. The wake events are reset, either of two init requests, a non-maskable interrupt, a debug event, and a maskable interrupt that only counts while interrupts are enabled.

Each wake records a 3-bit cause code, and the code is held until the next halt. Software or debug logic can read it to learn why the core resumed. Non-maskable, debug and init events wake the core whatever the interrupt-enable flag says. A masked maskable request leaves the core halted. If a non-maskable handler returns straight to the halt opcode, the next strobe halts the core again. All pins are plain control and status signals, with no stream handshake.

Top module: `hw_halt_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, halted is 0, fetch_en is 1 and wake_cause is 1 (reset). Reset acts asynchronously.
- R2: If halt_strobe is high while running, then from the next rising edge halted is 1, fetch_en is 0 and wake_cause is 0 (none).
- R3: While halted, fetch_en stays 0 and halted stays 1 until a qualifying wake event arrives. halt_strobe has no effect while halted.
- R4: A maskable request (irq) with int_en high wakes the core and sets wake_cause to 5.
- R5: A maskable request with int_en low does not wake the core, and it stays halted.
- R6: A non-maskable interrupt (nmi) wakes the core whatever int_en is, and sets wake_cause to 3.
- R7: A debug event wakes the core and sets wake_cause to 4. Either init_local or init_global wakes the core and sets wake_cause to 2.
- R8: When several wake events arrive in the same cycle, init wins over nmi, nmi over debug, and debug over an enabled irq. Reset overrides everything.
- R9: A wake event sampled at a rising edge makes halted 0 and fetch_en 1 from that edge, so fetching resumes on the following cycle.
- R10: While running, wake_cause holds its value and wake inputs have no effect. A later halt_strobe, for example after a non-maskable handler returns to the halt opcode, halts the core again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_strobe | input | 1 | Decoder saw the halt opcode (one cycle) |
| int_en | input | 1 | Maskable interrupts enabled |
| irq | input | 1 | Maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt |
| dbg_evt | input | 1 | Debug event |
| init_local | input | 1 | Core-local init request |
| init_global | input | 1 | System-wide init request |
| halted | output | 1 | Core is in the halted state |
| fetch_en | output | 1 | Instruction fetch allowed |
| wake_cause | output | 3 | Cause of the last wake: 0 none, 1 reset, 2 init, 3 nmi, 4 debug, 5 irq |

## Verification
The bench builds the block with its default parameters: a 3-bit cause code and four arbitrated wake sources. At these values every cause code and every pairing of simultaneous sources can be reached, from the full collision down to debug against an enabled irq. The masked-irq case is held over several cycles before a real wake source releases the core. A handler that returns to the halt opcode is replayed to show the core halts again.

// File: rtl/hw_halt_pkg.sv
package hw_halt_pkg;
  localparam int CAUSE_W = 3;
  localparam int NUM_SRC = 4;

  typedef enum logic [CAUSE_W-1:0] {
    WC_NONE  = 3'd0,
    WC_RESET = 3'd1,
    WC_INIT  = 3'd2,
    WC_NMI   = 3'd3,
    WC_DEBUG = 3'd4,
    WC_IRQ   = 3'd5
  } wake_cause_e;
endpackage

// File: rtl/hw_wake_arb.sv
// Fixed-priority pick among wake sources; index 0 has the highest priority.
// Code of source i is i + CODE_BASE.
module hw_wake_arb
  import hw_halt_pkg::*;
#(
  parameter int SRC_N     = NUM_SRC,
  parameter int CODE_BASE = 2
) (
  input  logic [SRC_N-1:0]   req,
  output logic               hit,
  output logic [CAUSE_W-1:0] code
);
  always_comb begin
    hit  = |req;
    code = WC_NONE;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (req[i]) code = CAUSE_W'(i + CODE_BASE);
    end
  end
endmodule

// File: rtl/hw_halt_reg.sv
module hw_halt_reg
  import hw_halt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_strobe,
  input  logic               wake_hit,
  input  logic [CAUSE_W-1:0] wake_code,
  output logic               halted,
  output logic [CAUSE_W-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      cause  <= WC_RESET;
    end else if (halted) begin
      if (wake_hit) begin
        halted <= 1'b0;
        cause  <= wake_code;
      end
    end else if (halt_strobe) begin
      halted <= 1'b1;
      cause  <= WC_NONE;
    end
  end

  // R2: a strobe while running enters halt
  a_r2_enter_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_strobe) |=> (halted && cause == WC_NONE));
  // R3: no wake keeps the core halted
  a_r3_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wake_hit) |=> halted);
  // R10: cause held while running without a strobe
  a_r10_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_strobe) |=> (!halted && $stable(cause)));
endmodule

// File: rtl/hw_halt_ctrl.sv
module hw_halt_ctrl
  import hw_halt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_strobe,
  input  logic               int_en,
  input  logic               irq,
  input  logic               nmi,
  input  logic               dbg_evt,
  input  logic               init_local,
  input  logic               init_global,
  output logic               halted,
  output logic               fetch_en,
  output logic [CAUSE_W-1:0] wake_cause
);
  logic [NUM_SRC-1:0] wake_req;
  logic               wake_hit;
  logic [CAUSE_W-1:0] wake_code;

  // priority order: init, nmi, debug, enabled irq
  assign wake_req = {irq & int_en, dbg_evt, nmi, init_local | init_global};

  hw_wake_arb #(.SRC_N(NUM_SRC), .CODE_BASE(2)) u_arb (
    .req  (wake_req),
    .hit  (wake_hit),
    .code (wake_code)
  );

  hw_halt_reg u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_strobe (halt_strobe),
    .wake_hit    (wake_hit),
    .wake_code   (wake_code),
    .halted      (halted),
    .cause       (wake_cause)
  );

  assign fetch_en = ~halted;

  // R5: masked irq alone never wakes
  a_r5_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && irq && !int_en && !nmi && !dbg_evt && !init_local && !init_global)
      |=> halted);
  // R6: nmi wakes regardless of int_en
  a_r6_nmi_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && nmi) |=> (!halted && fetch_en));
  // R8: init wins every collision
  a_r8_init_first: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && (init_local || init_global)) |=> (wake_cause == WC_INIT));
  // R4: enabled irq alone gives the irq code
  a_r4_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && irq && int_en && !nmi && !dbg_evt && !init_local && !init_global)
      |=> (wake_cause == WC_IRQ));
endmodule

// File: tb/hw_halt_ctrl_test.sv
module hw_halt_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_strobe = 1'b0, int_en = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic       dbg_evt = 1'b0, init_local = 1'b0, init_global = 1'b0;
  logic       halted, fetch_en;
  logic [2:0] wake_cause;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hw_halt_ctrl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic state(input string req, input int h, input int c);
    chk(req, halted, h);
    chk(req, fetch_en, 1 - h);
    chk(req, wake_cause, c);
  endtask

  // apply {init_local,init_global,nmi,dbg,irq,halt} for one edge, then clear
  task automatic pulse(input logic [5:0] v);
    {init_local, init_global, nmi, dbg_evt, irq, halt_strobe} = v;
    @(negedge clk);
    {init_local, init_global, nmi, dbg_evt, irq, halt_strobe} = '0;
  endtask

  task automatic do_halt(input string req);
    pulse(6'b000001);
    state(req, 1, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    state("R1", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    state("R1", 0, 1);
  endtask

  task automatic t_masked();
    do_halt("R2");
    int_en = 1'b0;
    irq = 1'b1;
    repeat (4) @(negedge clk);
    state("R5", 1, 0);
    irq = 1'b0;
    pulse(6'b000001);
    state("R3", 1, 0);
    pulse(6'b000100);
    state("R7", 0, 4);
  endtask

  task automatic t_irq();
    do_halt("R2");
    int_en = 1'b1;
    pulse(6'b000010);
    state("R4", 0, 5);
    state("R9", 0, 5);
  endtask

  task automatic t_nmi_rehalt();
    int_en = 1'b0;
    do_halt("R2");
    pulse(6'b001000);
    state("R6", 0, 3);
    repeat (2) @(negedge clk);
    state("R10", 0, 3);
    do_halt("R10");
    pulse(6'b001000);
    state("R6", 0, 3);
  endtask

  task automatic t_init();
    do_halt("R2");
    pulse(6'b100000);
    state("R7", 0, 2);
    do_halt("R2");
    pulse(6'b010000);
    state("R7", 0, 2);
  endtask

  task automatic t_priority();
    int_en = 1'b1;
    do_halt("R2");
    pulse(6'b111110);
    state("R8", 0, 2);
    do_halt("R2");
    pulse(6'b001110);
    state("R8", 0, 3);
    do_halt("R2");
    pulse(6'b000110);
    state("R8", 0, 4);
  endtask

  task automatic t_running_ignores();
    pulse(6'b111110);
    state("R10", 0, 4);
  endtask

  task automatic t_reset_halted();
    do_halt("R2");
    #2 rst_n = 1'b0;
    #1 state("R8", 0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    state("R1", 0, 1);
  endtask

  initial begin
    t_reset();
    t_masked();
    t_irq();
    t_nmi_rehalt();
    t_init();
    t_priority();
    t_running_ignores();
    t_reset_halted();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule